// File: doc/BRIEF.md
# Virtual Router Packet Dispatcher

The dispatcher sits between the physical ingress ports and the egress queues of a router that hosts several virtual networks. It takes one packet header per cycle. A classification table, indexed by the header's virtual destination address, names one of three outcomes for each packet. The packet can belong to a hardware forwarding slot, it can belong to the host software path, or it is unknown. A hardware packet looks up its output port in one forwarding memory. That memory is shared by all slots and partitioned by slot index. A host packet is handed out on the host-bound queue interface. Packets that host software has already resolved come back on a second input and go straight to their egress port with no lookup.

Each hardware slot has its own enable, so it can be taken offline for replacement or held idle while the other slots keep forwarding. Packets that cannot be delivered are reported on a drop strobe and counted. This covers headers that miss the classification table, headers aimed at an offline slot, and headers that hit an invalid forwarding entry. Both tables are loaded through a single register write port.

Top module: `vrd_dispatch`

## Requirements
- R1: After reset, every output strobe is low, `drop_count` is 0, and both tables are empty, so any ingress header is dropped.
- R2: A write with `wr_fwd`=0 loads classification entry `wr_addr[3:0]` from `wr_data`. Bit 3 is the valid flag, bit 2 selects the host path, and bits 1:0 give the hardware slot.
- R3: A write with `wr_fwd`=1 loads forwarding entry `wr_addr`, where bits 7:6 are the slot and bits 5:0 the route. In `wr_data`, bit 2 is the valid flag and bits 1:0 the egress port. A hardware packet leaves on the port stored at {slot, `in_route`}.
- R4: A packet classified for the host raises `host_valid` and carries its tag, source port, virtual address and route. It raises neither `eg_valid` nor `drop_valid`.
- R5: A resolved packet from the host (`sw_valid`) leaves on `eg_port` = `sw_port` with its tag, and skips both tables.
- R6: `sw_ready` is always 1. When `sw_valid` is high, `in_ready` is 0, so resolved packets from the host take priority over ingress headers.
- R7: A header accepted in cycle c produces exactly one result in cycle c+2. Headers accepted in consecutive cycles produce results in consecutive cycles, in acceptance order.
- R8: A drop happens on a classification miss, on an offline slot, or on an invalid forwarding entry. A drop raises `drop_valid` only. `drop_count` then rises by one in the next cycle and saturates at its maximum.
- R9: `slot_en[s]`=0, sampled when the header is accepted, drops packets for slot s. Packets for the other slots are forwarded unchanged.
- R10: A forwarding write only changes the entry it addresses. A write made in the cycle after a lookup is accepted does not change that lookup's result. Later lookups see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Ingress header valid |
| in_ready | output | 1 | Ingress header accepted |
| in_port | input | 2 | Physical ingress port |
| in_vaddr | input | 4 | Virtual destination address |
| in_route | input | 6 | Route index within the virtual network |
| in_tag | input | 8 | Packet tag carried through |
| sw_valid | input | 1 | Host-resolved packet valid |
| sw_ready | output | 1 | Host-resolved packet accepted |
| sw_port | input | 2 | Egress port chosen by host software |
| sw_tag | input | 8 | Tag of host-resolved packet |
| slot_en | input | 4 | Per-slot enable |
| wr_en | input | 1 | Table write strobe |
| wr_fwd | input | 1 | 1: forwarding memory, 0: classification table |
| wr_addr | input | 8 | Table write address |
| wr_data | input | 4 | Table write data |
| eg_valid | output | 1 | Egress queue push |
| eg_port | output | 2 | Egress queue selected |
| eg_tag | output | 8 | Tag of egress packet |
| host_valid | output | 1 | Host-bound queue push |
| host_tag | output | 8 | Tag of host packet |
| host_src_port | output | 2 | Ingress port of host packet |
| host_vaddr | output | 4 | Virtual address of host packet |
| host_route | output | 6 | Route index of host packet |
| drop_valid | output | 1 | Packet dropped |
| drop_count | output | CNT_W | Saturating drop counter |

## Verification
The hardest case to reach from the ports is a table write that lands on the same edge as a forwarding read still in flight. The stimulus sends a header in one cycle and, in the next cycle, rewrites the very entry that header is reading. It also rewrites a different slot's entry during the lookup. It then checks that the in-flight result keeps the old port and that the next lookup returns the new one. Priority is reached by raising an ingress header and a resolved return in the same cycle. Saturation is reached by building the bench with a narrow drop counter.

// File: rtl/vrd_pkg.sv
package vrd_pkg;
    localparam int NSLOT   = 4;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int NPORT   = 4;
    localparam int PORT_W  = $clog2(NPORT);
    localparam int ROUTE_W = 6;
    localparam int VADDR_W = 4;
    localparam int TAG_W   = 8;
    localparam int FWD_AW  = SLOT_W + ROUTE_W;
    localparam int CLS_W   = 2 + SLOT_W;
    localparam int WD_W    = CLS_W;

    typedef enum logic [1:0] {K_DROP, K_HOST, K_HW, K_BYPASS} kind_e;

    typedef struct packed {
        logic              valid;
        logic              to_host;
        logic [SLOT_W-1:0] slot;
    } cls_ent_t;

    typedef struct packed {
        logic              valid;
        logic [PORT_W-1:0] port;
    } fwd_ent_t;

    typedef struct packed {
        logic               vld;
        kind_e              kind;
        logic [TAG_W-1:0]   tag;
        logic [PORT_W-1:0]  port;
        logic [VADDR_W-1:0] vaddr;
        logic [ROUTE_W-1:0] route;
    } hdr_t;

    function automatic logic [FWD_AW-1:0] fwd_addr(input logic [SLOT_W-1:0] slot,
                                                   input logic [ROUTE_W-1:0] route);
        return {slot, route};
    endfunction
endpackage

// File: rtl/vrd_classify.sv
module vrd_classify
    import vrd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [VADDR_W-1:0] wr_addr,
    input  cls_ent_t           wr_data,
    input  logic [VADDR_W-1:0] rd_addr,
    output cls_ent_t           rd_ent
);
    localparam int DEPTH = 1 << VADDR_W;

    cls_ent_t table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) table_q[i] <= '0;
        end else if (wr_en) begin
            table_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read: the header is classified in its acceptance cycle
    assign rd_ent = table_q[rd_addr];
endmodule

// File: rtl/vrd_fwd_mem.sv
module vrd_fwd_mem
    import vrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FWD_AW-1:0] wr_addr,
    input  fwd_ent_t          wr_data,
    input  logic [FWD_AW-1:0] rd_addr,
    output fwd_ent_t          rd_ent
);
    localparam int ROUTES = 1 << ROUTE_W;

    fwd_ent_t bank_rd [NSLOT];

    // One partition per slot; a write only enables the bank it addresses
    for (genvar s = 0; s < NSLOT; s++) begin : g_bank
        fwd_ent_t mem [ROUTES];
        logic     hit_wr;

        assign hit_wr = wr_en && (wr_addr[FWD_AW-1:ROUTE_W] == SLOT_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < ROUTES; i++) mem[i] <= '0;
            end else if (hit_wr) begin
                mem[wr_addr[ROUTE_W-1:0]] <= wr_data;
            end
        end

        assign bank_rd[s] = mem[rd_addr[ROUTE_W-1:0]];
    end

    // Registered read: returns the content held before a same-edge write
    always_ff @(posedge clk) begin
        if (rst) rd_ent <= '0;
        else     rd_ent <= bank_rd[rd_addr[FWD_AW-1:ROUTE_W]];
    end
endmodule

// File: rtl/vrd_resolve.sv
module vrd_resolve
    import vrd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  hdr_t               s1,
    input  fwd_ent_t           fwd,
    output logic               eg_valid,
    output logic [PORT_W-1:0]  eg_port,
    output logic [TAG_W-1:0]   eg_tag,
    output logic               host_valid,
    output logic [TAG_W-1:0]   host_tag,
    output logic [PORT_W-1:0]  host_src_port,
    output logic [VADDR_W-1:0] host_vaddr,
    output logic [ROUTE_W-1:0] host_route,
    output logic               drop_valid,
    output logic [CNT_W-1:0]   drop_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    hdr_t s2;

    always_ff @(posedge clk) begin
        if (rst) s2 <= '0;
        else     s2 <= s1;
    end

    always_comb begin
        eg_valid   = 1'b0;
        host_valid = 1'b0;
        drop_valid = 1'b0;
        eg_port    = fwd.port;
        if (s2.vld) begin
            unique case (s2.kind)
                K_BYPASS: begin eg_valid = 1'b1; eg_port = s2.port; end
                K_HOST:   host_valid = 1'b1;
                K_HW:     begin eg_valid = fwd.valid; drop_valid = !fwd.valid; end
                default:  drop_valid = 1'b1;
            endcase
        end
    end

    assign eg_tag        = s2.tag;
    assign host_tag      = s2.tag;
    assign host_src_port = s2.port;
    assign host_vaddr    = s2.vaddr;
    assign host_route    = s2.route;

    always_ff @(posedge clk) begin
        if (rst)                                drop_count <= '0;
        else if (drop_valid && drop_count != CNT_MAX) drop_count <= drop_count + 1'b1;
    end

    // R8: a drop is reported alone
    p_one_result_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eg_valid, host_valid, drop_valid}));

    // R8: counter steps by one per drop until full
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
        (drop_valid && drop_count != CNT_MAX) |=> (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: rtl/vrd_dispatch.sv
module vrd_dispatch
    import vrd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PORT_W-1:0]  in_port,
    input  logic [VADDR_W-1:0] in_vaddr,
    input  logic [ROUTE_W-1:0] in_route,
    input  logic [TAG_W-1:0]   in_tag,
    input  logic               sw_valid,
    output logic               sw_ready,
    input  logic [PORT_W-1:0]  sw_port,
    input  logic [TAG_W-1:0]   sw_tag,
    input  logic [NSLOT-1:0]   slot_en,
    input  logic               wr_en,
    input  logic               wr_fwd,
    input  logic [FWD_AW-1:0]  wr_addr,
    input  logic [WD_W-1:0]    wr_data,
    output logic               eg_valid,
    output logic [PORT_W-1:0]  eg_port,
    output logic [TAG_W-1:0]   eg_tag,
    output logic               host_valid,
    output logic [TAG_W-1:0]   host_tag,
    output logic [PORT_W-1:0]  host_src_port,
    output logic [VADDR_W-1:0] host_vaddr,
    output logic [ROUTE_W-1:0] host_route,
    output logic               drop_valid,
    output logic [CNT_W-1:0]   drop_count
);
    cls_ent_t          cls;
    fwd_ent_t          fwd;
    hdr_t              nxt, s1;
    logic [SLOT_W-1:0] s1_slot;

    // Resolved packets from the host win the single issue slot
    assign sw_ready = 1'b1;
    assign in_ready = !sw_valid;

    vrd_classify u_cls (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && !wr_fwd),
        .wr_addr (wr_addr[VADDR_W-1:0]),
        .wr_data (cls_ent_t'(wr_data[CLS_W-1:0])),
        .rd_addr (in_vaddr),
        .rd_ent  (cls)
    );

    always_comb begin
        nxt = '0;
        if (sw_valid) begin
            nxt.vld  = 1'b1;
            nxt.kind = K_BYPASS;
            nxt.tag  = sw_tag;
            nxt.port = sw_port;
        end else if (in_valid) begin
            nxt.vld   = 1'b1;
            nxt.tag   = in_tag;
            nxt.port  = in_port;
            nxt.vaddr = in_vaddr;
            nxt.route = in_route;
            if (!cls.valid)             nxt.kind = K_DROP;
            else if (cls.to_host)       nxt.kind = K_HOST;
            else if (!slot_en[cls.slot]) nxt.kind = K_DROP;
            else                        nxt.kind = K_HW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= '0;
            s1_slot <= '0;
        end else begin
            s1      <= nxt;
            s1_slot <= cls.slot;
        end
    end

    vrd_fwd_mem u_fwd (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && wr_fwd),
        .wr_addr (wr_addr),
        .wr_data (fwd_ent_t'(wr_data[PORT_W:0])),
        .rd_addr (fwd_addr(s1_slot, s1.route)),
        .rd_ent  (fwd)
    );

    vrd_resolve #(.CNT_W(CNT_W)) u_res (
        .clk           (clk),
        .rst           (rst),
        .s1            (s1),
        .fwd           (fwd),
        .eg_valid      (eg_valid),
        .eg_port       (eg_port),
        .eg_tag        (eg_tag),
        .host_valid    (host_valid),
        .host_tag      (host_tag),
        .host_src_port (host_src_port),
        .host_vaddr    (host_vaddr),
        .host_route    (host_route),
        .drop_valid    (drop_valid),
        .drop_count    (drop_count)
    );

    // R7: each accepted header yields a result two cycles later
    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ##1 (eg_valid || host_valid || drop_valid));

    // R5: a resolved return leaves on its own port with its own tag
    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        sw_valid |=> ##1 (eg_valid && eg_port == $past(sw_port, 2) && eg_tag == $past(sw_tag, 2)));

    // R9: a header for an offline slot ends as a drop
    p_offline_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && cls.valid && !cls.to_host && !slot_en[cls.slot])
        |=> ##1 (drop_valid && !eg_valid));
endmodule

// File: tb/tb_vrd_dispatch.sv
module tb_vrd_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 3;
    localparam int CNT_MAX    = 7;
    localparam int EK_DROP = 0, EK_HOST = 1, EK_EG = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 0, sw_valid = 0, wr_en = 0, wr_fwd = 0;
    logic [1:0] in_port = 0, sw_port = 0;
    logic [3:0] in_vaddr = 0, slot_en = 4'b0111, wr_data = 0;
    logic [5:0] in_route = 0;
    logic [7:0] in_tag = 0, sw_tag = 0, wr_addr = 0;
    logic       in_ready, sw_ready, eg_valid, host_valid, drop_valid;
    logic [1:0] eg_port, host_src_port;
    logic [7:0] eg_tag, host_tag;
    logic [3:0] host_vaddr;
    logic [5:0] host_route;
    logic [CNT_W-1:0] drop_count;

    int nchk = 0, nfail = 0, exp_drops = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vrd_dispatch #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_port(in_port),
        .in_vaddr(in_vaddr), .in_route(in_route), .in_tag(in_tag),
        .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_port(sw_port), .sw_tag(sw_tag),
        .slot_en(slot_en), .wr_en(wr_en), .wr_fwd(wr_fwd), .wr_addr(wr_addr), .wr_data(wr_data),
        .eg_valid(eg_valid), .eg_port(eg_port), .eg_tag(eg_tag),
        .host_valid(host_valid), .host_tag(host_tag), .host_src_port(host_src_port),
        .host_vaddr(host_vaddr), .host_route(host_route),
        .drop_valid(drop_valid), .drop_count(drop_count)
    );

    typedef struct packed {
        logic [3:0] va;
        logic [5:0] rt;
        logic [1:0] pt;
        logic [7:0] tag;
        logic [1:0] ek;
        logic [1:0] ep;
    } vec_t;

    // R3/R4/R8/R9 vectors against the tables loaded below
    localparam vec_t VEC [0:7] = '{
        '{4'd0, 6'd5, 2'd0, 8'h11, 2'd2, 2'd3},
        '{4'd1, 6'd5, 2'd2, 8'h22, 2'd2, 2'd1},
        '{4'd2, 6'd5, 2'd1, 8'h33, 2'd1, 2'd0},
        '{4'd3, 6'd9, 2'd3, 8'h44, 2'd2, 2'd2},
        '{4'd4, 6'd5, 2'd0, 8'h55, 2'd0, 2'd0},
        '{4'd5, 6'd0, 2'd1, 8'h66, 2'd0, 2'd0},
        '{4'd0, 6'd7, 2'd2, 8'h77, 2'd0, 2'd0},
        '{4'd1, 6'd5, 2'd3, 8'h88, 2'd2, 2'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check the result strobes/fields visible now
    task automatic expect_out(input int ek, input int ep, input logic [7:0] tag,
                              input logic [1:0] pt, input logic [3:0] va,
                              input logic [5:0] rt, input string req);
        int act, exp;
        act = {eg_valid, host_valid, drop_valid};
        exp = (ek == EK_EG) ? 4 : (ek == EK_HOST) ? 2 : 1;
        chk(act == exp, {req, " strobes"}, act, exp);
        if (ek == EK_EG) begin
            chk(eg_port == ep && eg_tag == tag, {req, " egress port"}, eg_port, ep);
        end else if (ek == EK_HOST) begin
            chk(host_tag == tag && host_src_port == pt && host_vaddr == va && host_route == rt,
                {req, " host fields"}, host_tag, tag);
        end
    endtask

    task automatic note_drop(input int ek);
        if (ek == EK_DROP && exp_drops < CNT_MAX) exp_drops++;
    endtask

    task automatic issue(input logic [3:0] va, input logic [5:0] rt, input logic [1:0] pt,
                         input logic [7:0] tag, input int ek, input int ep, input string req);
        @(negedge clk);
        in_valid = 1; in_vaddr = va; in_route = rt; in_port = pt; in_tag = tag;
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
        expect_out(ek, ep, tag, pt, va, rt, req);
        note_drop(ek);
        @(negedge clk);
        chk(drop_count == exp_drops, {req, " drop count"}, drop_count, exp_drops);
    endtask

    task automatic wr(input bit fwd, input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1; wr_fwd = fwd; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(in_ready && sw_ready, "R1 ready after reset", {in_ready, sw_ready}, 3);
        chk({eg_valid, host_valid, drop_valid} == 0, "R1 strobes low", {eg_valid, host_valid, drop_valid}, 0);
        chk(drop_count == 0, "R1 drop count", drop_count, 0);
        issue(4'd0, 6'd5, 2'd0, 8'h01, EK_DROP, 0, "R1 empty table");

        // R2 classification entries, R3 forwarding entries
        wr(0, 8'd0, 4'b1000);
        wr(0, 8'd1, 4'b1001);
        wr(0, 8'd2, 4'b1100);
        wr(0, 8'd3, 4'b1010);
        wr(0, 8'd4, 4'b1011);
        wr(1, 8'd5,   4'b0111);
        wr(1, 8'd69,  4'b0101);
        wr(1, 8'd137, 4'b0110);
        wr(1, 8'd197, 4'b0100);

        for (int i = 0; i < 8; i++) begin
            issue(VEC[i].va, VEC[i].rt, VEC[i].pt, VEC[i].tag, int'(VEC[i].ek), int'(VEC[i].ep),
                  $sformatf("R3 R4 R8 vector %0d", i));
        end

        // R7 back-to-back headers keep order and latency
        @(negedge clk);
        in_valid = 1; in_vaddr = 0; in_route = 5; in_port = 0; in_tag = 8'hA1;
        @(negedge clk);
        in_vaddr = 2; in_route = 3; in_port = 1; in_tag = 8'hA2;
        @(negedge clk);
        expect_out(EK_EG, 3, 8'hA1, 0, 0, 5, "R7 first");
        in_vaddr = 1; in_route = 5; in_port = 2; in_tag = 8'hA3;
        @(negedge clk);
        in_valid = 0;
        expect_out(EK_HOST, 0, 8'hA2, 1, 2, 3, "R7 second");
        @(negedge clk);
        expect_out(EK_EG, 1, 8'hA3, 2, 1, 5, "R7 third");
        @(negedge clk);

        // R6 priority, R5 bypass
        @(negedge clk);
        in_valid = 1; in_vaddr = 0; in_route = 5; in_port = 1; in_tag = 8'hAA;
        sw_valid = 1; sw_port = 2; sw_tag = 8'hBB;
        #1;
        chk(!in_ready && sw_ready, "R6 ingress held", in_ready, 0);
        @(negedge clk);
        sw_valid = 0;
        #1;
        chk(in_ready, "R6 ingress released", in_ready, 1);
        @(negedge clk);
        in_valid = 0;
        expect_out(EK_EG, 2, 8'hBB, 0, 0, 0, "R5 returned packet");
        @(negedge clk);
        expect_out(EK_EG, 3, 8'hAA, 1, 0, 5, "R6 deferred header");

        // R10 writes during a lookup
        @(negedge clk);
        in_valid = 1; in_vaddr = 0; in_route = 5; in_port = 0; in_tag = 8'hC1;
        wr_en = 1; wr_fwd = 1; wr_addr = 8'd69; wr_data = 4'b0110;
        @(negedge clk);
        in_valid = 0;
        wr_addr = 8'd5; wr_data = 4'b0100;
        @(negedge clk);
        wr_en = 0;
        expect_out(EK_EG, 3, 8'hC1, 0, 0, 5, "R10 in-flight lookup old entry");
        issue(4'd0, 6'd5, 2'd0, 8'hC2, EK_EG, 0, "R10 new entry same slot");
        issue(4'd1, 6'd5, 2'd0, 8'hC3, EK_EG, 2, "R10 other slot entry");

        // R9 slot enables
        slot_en = 4'b1110;
        issue(4'd0, 6'd5, 2'd3, 8'hD1, EK_DROP, 0, "R9 offline slot dropped");
        issue(4'd4, 6'd5, 2'd3, 8'hD2, EK_EG, 0, "R9 enabled slot forwards");
        issue(4'd1, 6'd5, 2'd3, 8'hD3, EK_EG, 2, "R9 neighbour unaffected");

        // R8 saturation
        for (int i = 0; i < 4; i++) begin
            issue(4'd9, 6'd0, 2'd0, 8'(8'hE0 + i), EK_DROP, 0, "R8 saturating drops");
        end
        chk(drop_count == CNT_MAX, "R8 saturated", drop_count, CNT_MAX);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule